// File: doc/BRIEF.md
# Memory Dependency Group Tracker

This block keeps a fixed table of memory dependency groups for an out-of-order core's memory scheduler. A group collects memory operations that all wait on the same older work. For every group the block counts its predecessor groups (all of them, those that have started, those that have finished) and its own member operations (all of them, issued, completed). From these six counters it derives five status conditions per group: waiting, pending, ready, executing and executed.

The block takes one command per clock: create a group, add a member operation, add a successor edge, report that a member operation issued, or report that one completed. Successor edges come in two kinds. An order edge is released once the source group has issued every member. A data edge is released only when every member of the source group has completed. All successor updates that one command causes land in the same clock edge. A separate tick input ages a per-group critical-predecessor latency estimate. A malformed command sets a sticky error flag and changes no state.

Top module: `mdg_tracker`

## Requirements
- R1: After reset no group is live, `next_id_o` is 1, `err_o` is 0 and every status and latency output is 0. A create command (code 1) makes group `next_id_o` live and increments `next_id_o`. When `next_id_o` equals NUM_GROUPS, a create is rejected. Live groups never become dead except by reset.
- R2: For a live group with P predecessors, I issued predecessors and C completed predecessors: waiting is P > I + C, pending is I != 0 and I + C == P, and ready is C == P. A group that is not live shows 0 on every flag.
- R3: For a live group with M members, S issued members and D completed members: executing is S != 0 and S == M - D, and executed is D == M. An issue command (code 4) increments S and raises the group's critical member latency to the command's latency if that value is larger. A complete command (code 5) decrements S and increments D.
- R4: When an issue makes its group executing, each order successor's C rises by 1 with I unchanged. Each data successor's I rises by 1, and its latency becomes the larger of its current value and the source's critical member latency.
- R5: When a complete makes its group executed, each data successor's I falls by 1 and its C rises by 1. Order successors are not touched.
- R6: An add-successor command (code 3; source `cmd_gid_i`, target `cmd_dst_i`, `cmd_data_i`=1 for a data edge) has no effect and raises no error when it asks for an order edge and the source is executing. Otherwise it records the edge and increments the target's P. If the source is executing, the same edge also increments the target's I and, for a data edge, raises the target's latency to the source's critical member latency.
- R7: An add-member command (code 2) increments M. It is rejected when the group already has any successor edge, or when M is at its maximum.
- R8: On each clock with `tick_i` high, the latency of every waiting group with a nonzero latency drops by 1. If a data issue event hits the same group in the same clock, the result is the larger of the decremented value and the event's latency. Latency is reported on `crit_o`, group g at bits g*CYC_W upward.
- R9: A rejected command sets `err_o` and leaves every counter, edge, live bit and `next_id_o` unchanged; `err_o` clears only on reset. The tick still applies. Commands are rejected in these cases: a source (and, for code 3, target) ID that is 0 or not live. Code 3 when the target equals the source, the source is executed, the edge already exists, or the target's P is at its maximum. Code 4 when S + D == M. Code 5 when S == 0.
- R10: Code 0 and the unused codes 6 and 7 change no state and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op_i | input | 3 | Command code (0 idle, 1 create, 2 add member, 3 add successor, 4 issue, 5 complete) |
| cmd_gid_i | input | log2(NUM_GROUPS) | Group the command acts on (source for code 3) |
| cmd_dst_i | input | log2(NUM_GROUPS) | Target group of an add-successor command |
| cmd_data_i | input | 1 | 1 = data edge, 0 = order edge |
| cmd_cyc_i | input | CYC_W | Remaining latency of the issued operation |
| tick_i | input | 1 | Per-cycle aging strobe for latency estimates |
| live_o | output | NUM_GROUPS | Group has been created |
| waiting_o | output | NUM_GROUPS | Some predecessor has not started |
| pending_o | output | NUM_GROUPS | All predecessors started, some still running |
| ready_o | output | NUM_GROUPS | All predecessors completed |
| executing_o | output | NUM_GROUPS | Every unfinished member has issued |
| executed_o | output | NUM_GROUPS | Every member has completed |
| crit_o | output | NUM_GROUPS*CYC_W | Critical-predecessor latency per group |
| next_id_o | output | log2(NUM_GROUPS)+1 | ID the next create will allocate |
| err_o | output | 1 | Sticky rejected-command flag |

## Verification
Random command streams are mixed in proportions that build fan-out and fan-in graphs of both edge kinds. Running them until counters saturate and the table fills separates a correct release rule (order on full issue, data on full completion) from variants that release too early or twice. Directed sequences pin down the cases that random streams rarely hit. These are an order edge added to an already executing source, a data edge added to an executing source, latency aging while pending against while waiting, and member addition after a successor exists. Illegal IDs and unused codes check that a rejected command leaves every visible flag and latency where it was.

// File: rtl/mdg_pkg.sv
// Package: shared command encoding for the memory dependency group tracker.
// Assumes one command per clock; codes 6 and 7 are reserved and act as idle.
package mdg_pkg;
    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_CREATE   = 3'd1,
        OP_ADD_MEM  = 3'd2,
        OP_ADD_SUCC = 3'd3,
        OP_ISSUE    = 3'd4,
        OP_DONE     = 3'd5
    } mdg_op_e;
endpackage

// File: rtl/mdg_group_slot.sv
// Module: one table entry. Holds the six counters, both successor vectors,
// the critical member latency and the critical predecessor latency, and
// derives the five status flags. Assumes the caller has already validated
// every event strobe, so no counter can wrap.
module mdg_group_slot #(
    parameter int NUM_GROUPS = 16,
    parameter int CNT_W      = 4,
    parameter int CYC_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_i,
    input  logic                  mem_add_i,
    input  logic                  mem_iss_i,
    input  logic [CYC_W-1:0]      mem_cyc_i,
    input  logic                  mem_done_i,
    input  logic                  pred_add_i,
    input  logic                  pred_iss_i,
    input  logic                  pred_rel_i,
    input  logic                  pred_done_i,
    input  logic                  crit_upd_i,
    input  logic [CYC_W-1:0]      crit_val_i,
    input  logic                  tick_i,
    input  logic                  edge_set_i,
    input  logic                  edge_data_i,
    input  logic [NUM_GROUPS-1:0] edge_dst_i,
    output logic                  live_o,
    output logic [CNT_W-1:0]      pred_o,
    output logic [CNT_W-1:0]      mem_o,
    output logic [CNT_W-1:0]      iss_o,
    output logic [CNT_W-1:0]      cmp_o,
    output logic [NUM_GROUPS-1:0] ord_vec_o,
    output logic [NUM_GROUPS-1:0] dat_vec_o,
    output logic [CYC_W-1:0]      crit_mem_o,
    output logic [CYC_W-1:0]      crit_pred_o,
    output logic                  waiting_o,
    output logic                  pending_o,
    output logic                  ready_o,
    output logic                  executing_o,
    output logic                  executed_o
);
    localparam int SUM_W = CNT_W + 1;

    logic                  live_q;
    logic [CNT_W-1:0]      pred_q, ipred_q, cpred_q;
    logic [CNT_W-1:0]      mem_q, iss_q, cmp_q;
    logic [NUM_GROUPS-1:0] ord_q, dat_q;
    logic [CYC_W-1:0]      critm_q, critp_q;
    logic [SUM_W-1:0]      pred_sum;
    logic [CNT_W-1:0]      open_cnt;
    logic                  wait_raw, exec_raw, done_raw;
    logic [CYC_W-1:0]      critp_tick, critp_next, critm_next;

    // Purpose: derive the status conditions from the counters.
    always_comb begin
        pred_sum = {1'b0, ipred_q} + {1'b0, cpred_q};
        open_cnt = mem_q - cmp_q;
        wait_raw = {1'b0, pred_q} > pred_sum;
        exec_raw = (iss_q != '0) && (iss_q == open_cnt);
        done_raw = (cmp_q == mem_q);
    end

    // Purpose: age the predecessor latency, then merge a data issue event.
    always_comb begin
        critp_tick = (tick_i && wait_raw && critp_q != '0) ? critp_q - 1'b1 : critp_q;
        critp_next = (crit_upd_i && crit_val_i > critp_tick) ? crit_val_i : critp_tick;
        critm_next = (mem_iss_i && mem_cyc_i > critm_q) ? mem_cyc_i : critm_q;
    end

    // Purpose: update all per-group state from the event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= 1'b0;
            pred_q  <= '0;
            ipred_q <= '0;
            cpred_q <= '0;
            mem_q   <= '0;
            iss_q   <= '0;
            cmp_q   <= '0;
            ord_q   <= '0;
            dat_q   <= '0;
            critm_q <= '0;
            critp_q <= '0;
        end else begin
            if (alloc_i) live_q <= 1'b1;
            pred_q  <= pred_q + CNT_W'(pred_add_i);
            ipred_q <= ipred_q + CNT_W'(pred_iss_i) - CNT_W'(pred_done_i);
            cpred_q <= cpred_q + CNT_W'(pred_rel_i) + CNT_W'(pred_done_i);
            mem_q   <= mem_q + CNT_W'(mem_add_i);
            iss_q   <= iss_q + CNT_W'(mem_iss_i) - CNT_W'(mem_done_i);
            cmp_q   <= cmp_q + CNT_W'(mem_done_i);
            critm_q <= critm_next;
            critp_q <= critp_next;
            if (edge_set_i && edge_data_i)  dat_q <= dat_q | edge_dst_i;
            if (edge_set_i && !edge_data_i) ord_q <= ord_q | edge_dst_i;
        end
    end

    // Purpose: drive the outputs, masking flags of groups not yet created.
    always_comb begin
        live_o      = live_q;
        pred_o      = pred_q;
        mem_o       = mem_q;
        iss_o       = iss_q;
        cmp_o       = cmp_q;
        ord_vec_o   = ord_q;
        dat_vec_o   = dat_q;
        crit_mem_o  = critm_q;
        crit_pred_o = critp_q;
        waiting_o   = live_q && wait_raw;
        pending_o   = live_q && (ipred_q != '0) && (pred_sum == {1'b0, pred_q});
        ready_o     = live_q && (cpred_q == pred_q);
        executing_o = live_q && exec_raw;
        executed_o  = live_q && done_raw;
    end

    p_member_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, iss_q} + {1'b0, cmp_q}) <= {1'b0, mem_q});

    p_pred_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_sum <= {1'b0, pred_q});

    p_exec_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(executing_o && executed_o));

    p_crit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!crit_upd_i && !tick_i) |=> $stable(critp_q));
endmodule

// File: rtl/mdg_cmd_check.sv
// Module: validates the command against the current table state and turns it
// into one accept strobe or a reject strobe. Purely combinational; assumes
// NUM_GROUPS is a power of two so every ID indexes the table.
module mdg_cmd_check
    import mdg_pkg::*;
#(
    parameter int NUM_GROUPS = 16,
    parameter int CNT_W      = 4,
    localparam int ID_W      = $clog2(NUM_GROUPS)
) (
    input  logic [2:0]            op_i,
    input  logic [ID_W-1:0]       gid_i,
    input  logic [ID_W-1:0]       dst_i,
    input  logic [ID_W:0]         next_id_i,
    input  logic [NUM_GROUPS-1:0] live_i,
    input  logic [CNT_W-1:0]      src_mem_i,
    input  logic [CNT_W-1:0]      src_iss_i,
    input  logic [CNT_W-1:0]      src_cmp_i,
    input  logic                  src_executed_i,
    input  logic [NUM_GROUPS-1:0] src_ord_i,
    input  logic [NUM_GROUPS-1:0] src_dat_i,
    input  logic [CNT_W-1:0]      dst_pred_i,
    output logic                  do_create_o,
    output logic                  do_add_mem_o,
    output logic                  do_add_succ_o,
    output logic                  do_issue_o,
    output logic                  do_done_o,
    output logic                  reject_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [ID_W:0]    ID_LIM  = (ID_W+1)'(NUM_GROUPS);

    logic gid_ok, dst_ok, has_succ, edge_seen;
    logic [CNT_W:0] used_cnt;

    // Purpose: common validity terms.
    always_comb begin
        gid_ok    = (gid_i != '0) && live_i[gid_i];
        dst_ok    = (dst_i != '0) && live_i[dst_i];
        has_succ  = |(src_ord_i | src_dat_i);
        edge_seen = src_ord_i[dst_i] | src_dat_i[dst_i];
        used_cnt  = {1'b0, src_iss_i} + {1'b0, src_cmp_i};
    end

    // Purpose: accept or reject the command.
    always_comb begin
        do_create_o   = 1'b0;
        do_add_mem_o  = 1'b0;
        do_add_succ_o = 1'b0;
        do_issue_o    = 1'b0;
        do_done_o     = 1'b0;
        reject_o      = 1'b0;
        case (op_i)
            OP_CREATE: begin
                reject_o    = (next_id_i == ID_LIM);
                do_create_o = !reject_o;
            end
            OP_ADD_MEM: begin
                reject_o     = !gid_ok || has_succ || (src_mem_i == CNT_MAX);
                do_add_mem_o = !reject_o;
            end
            OP_ADD_SUCC: begin
                reject_o      = !gid_ok || !dst_ok || (dst_i == gid_i) || src_executed_i
                                || edge_seen || (dst_pred_i == CNT_MAX);
                do_add_succ_o = !reject_o;
            end
            OP_ISSUE: begin
                reject_o   = !gid_ok || (used_cnt == {1'b0, src_mem_i});
                do_issue_o = !reject_o;
            end
            OP_DONE: begin
                reject_o  = !gid_ok || (src_iss_i == '0);
                do_done_o = !reject_o;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mdg_event_route.sv
// Module: fans one accepted command out into per-group event strobes,
// including same-cycle release of every order and data successor. Assumes
// at most one accept strobe is high and that the source is never its own
// successor.
module mdg_event_route #(
    parameter int NUM_GROUPS = 16,
    parameter int CNT_W      = 4,
    parameter int CYC_W      = 6,
    localparam int ID_W      = $clog2(NUM_GROUPS)
) (
    input  logic                  do_create_i,
    input  logic                  do_add_mem_i,
    input  logic                  do_add_succ_i,
    input  logic                  do_issue_i,
    input  logic                  do_done_i,
    input  logic [ID_W-1:0]       gid_i,
    input  logic [ID_W-1:0]       dst_i,
    input  logic [ID_W-1:0]       next_idx_i,
    input  logic                  edge_data_i,
    input  logic [CYC_W-1:0]      cyc_i,
    input  logic [CNT_W-1:0]      src_mem_i,
    input  logic [CNT_W-1:0]      src_iss_i,
    input  logic [CNT_W-1:0]      src_cmp_i,
    input  logic                  src_executing_i,
    input  logic [NUM_GROUPS-1:0] src_ord_i,
    input  logic [NUM_GROUPS-1:0] src_dat_i,
    input  logic [CYC_W-1:0]      src_crit_mem_i,
    output logic [NUM_GROUPS-1:0] alloc_o,
    output logic [NUM_GROUPS-1:0] mem_add_o,
    output logic [NUM_GROUPS-1:0] mem_iss_o,
    output logic [NUM_GROUPS-1:0] mem_done_o,
    output logic [NUM_GROUPS-1:0] pred_add_o,
    output logic [NUM_GROUPS-1:0] pred_iss_o,
    output logic [NUM_GROUPS-1:0] pred_rel_o,
    output logic [NUM_GROUPS-1:0] pred_done_o,
    output logic [NUM_GROUPS-1:0] crit_upd_o,
    output logic [CYC_W-1:0]      crit_val_o,
    output logic [NUM_GROUPS-1:0] edge_set_o,
    output logic [NUM_GROUPS-1:0] edge_dst_o
);
    localparam logic [NUM_GROUPS-1:0] ONE = NUM_GROUPS'(1);

    logic [NUM_GROUPS-1:0] gid_oh, dst_oh;
    logic                  goes_exec, goes_done, edge_live, edge_now;
    logic [CYC_W-1:0]      issue_crit;

    // Purpose: detect the source group's state transitions.
    always_comb begin
        gid_oh     = ONE << gid_i;
        dst_oh     = ONE << dst_i;
        goes_exec  = do_issue_i && (({1'b0, src_iss_i} + 1'b1) == {1'b0, src_mem_i - src_cmp_i});
        goes_done  = do_done_i && (({1'b0, src_cmp_i} + 1'b1) == {1'b0, src_mem_i});
        issue_crit = (cyc_i > src_crit_mem_i) ? cyc_i : src_crit_mem_i;
        edge_live  = do_add_succ_i && (edge_data_i || !src_executing_i);
        edge_now   = edge_live && src_executing_i;
    end

    // Purpose: build the per-group strobes.
    always_comb begin
        alloc_o     = do_create_i  ? (ONE << next_idx_i) : '0;
        mem_add_o   = do_add_mem_i ? gid_oh : '0;
        mem_iss_o   = do_issue_i   ? gid_oh : '0;
        mem_done_o  = do_done_i    ? gid_oh : '0;
        pred_add_o  = edge_live    ? dst_oh : '0;
        pred_iss_o  = (edge_now ? dst_oh : '0) | (goes_exec ? src_dat_i : '0);
        pred_rel_o  = goes_exec ? src_ord_i : '0;
        pred_done_o = goes_done ? src_dat_i : '0;
        crit_upd_o  = ((edge_now && edge_data_i) ? dst_oh : '0) | (goes_exec ? src_dat_i : '0);
        crit_val_o  = do_issue_i ? issue_crit : src_crit_mem_i;
        edge_set_o  = edge_live ? gid_oh : '0;
        edge_dst_o  = dst_oh;
    end
endmodule

// File: rtl/mdg_tracker.sv
// Module: top of the memory dependency group tracker. Holds the ID allocator
// and the sticky error flag, muxes the addressed group's state to the command
// checker and the event router, and instantiates one slot per table entry.
// Assumes NUM_GROUPS is a power of two and one command per clock.
module mdg_tracker #(
    parameter int NUM_GROUPS = 16,
    parameter int CNT_W      = 4,
    parameter int CYC_W      = 6,
    localparam int ID_W      = $clog2(NUM_GROUPS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  cmd_op_i,
    input  logic [ID_W-1:0]             cmd_gid_i,
    input  logic [ID_W-1:0]             cmd_dst_i,
    input  logic                        cmd_data_i,
    input  logic [CYC_W-1:0]            cmd_cyc_i,
    input  logic                        tick_i,
    output logic [NUM_GROUPS-1:0]       live_o,
    output logic [NUM_GROUPS-1:0]       waiting_o,
    output logic [NUM_GROUPS-1:0]       pending_o,
    output logic [NUM_GROUPS-1:0]       ready_o,
    output logic [NUM_GROUPS-1:0]       executing_o,
    output logic [NUM_GROUPS-1:0]       executed_o,
    output logic [NUM_GROUPS*CYC_W-1:0] crit_o,
    output logic [ID_W:0]               next_id_o,
    output logic                        err_o
);
    logic [ID_W:0] next_id_q;
    logic          err_q;

    logic [CNT_W-1:0]      pred_a [NUM_GROUPS];
    logic [CNT_W-1:0]      mem_a  [NUM_GROUPS];
    logic [CNT_W-1:0]      iss_a  [NUM_GROUPS];
    logic [CNT_W-1:0]      cmp_a  [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] ord_a  [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] dat_a  [NUM_GROUPS];
    logic [CYC_W-1:0]      critm_a[NUM_GROUPS];

    logic [NUM_GROUPS-1:0] live_v, exec_v, done_v;
    logic do_create, do_add_mem, do_add_succ, do_issue, do_done, reject;
    logic [NUM_GROUPS-1:0] alloc_v, mem_add_v, mem_iss_v, mem_done_v;
    logic [NUM_GROUPS-1:0] pred_add_v, pred_iss_v, pred_rel_v, pred_done_v;
    logic [NUM_GROUPS-1:0] crit_upd_v, edge_set_v, edge_dst_v;
    logic [CYC_W-1:0]      crit_val;

    mdg_cmd_check #(.NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W)) u_check (
        .op_i          (cmd_op_i),
        .gid_i         (cmd_gid_i),
        .dst_i         (cmd_dst_i),
        .next_id_i     (next_id_q),
        .live_i        (live_v),
        .src_mem_i     (mem_a[cmd_gid_i]),
        .src_iss_i     (iss_a[cmd_gid_i]),
        .src_cmp_i     (cmp_a[cmd_gid_i]),
        .src_executed_i(done_v[cmd_gid_i]),
        .src_ord_i     (ord_a[cmd_gid_i]),
        .src_dat_i     (dat_a[cmd_gid_i]),
        .dst_pred_i    (pred_a[cmd_dst_i]),
        .do_create_o   (do_create),
        .do_add_mem_o  (do_add_mem),
        .do_add_succ_o (do_add_succ),
        .do_issue_o    (do_issue),
        .do_done_o     (do_done),
        .reject_o      (reject)
    );

    mdg_event_route #(.NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_route (
        .do_create_i    (do_create),
        .do_add_mem_i   (do_add_mem),
        .do_add_succ_i  (do_add_succ),
        .do_issue_i     (do_issue),
        .do_done_i      (do_done),
        .gid_i          (cmd_gid_i),
        .dst_i          (cmd_dst_i),
        .next_idx_i     (next_id_q[ID_W-1:0]),
        .edge_data_i    (cmd_data_i),
        .cyc_i          (cmd_cyc_i),
        .src_mem_i      (mem_a[cmd_gid_i]),
        .src_iss_i      (iss_a[cmd_gid_i]),
        .src_cmp_i      (cmp_a[cmd_gid_i]),
        .src_executing_i(exec_v[cmd_gid_i]),
        .src_ord_i      (ord_a[cmd_gid_i]),
        .src_dat_i      (dat_a[cmd_gid_i]),
        .src_crit_mem_i (critm_a[cmd_gid_i]),
        .alloc_o        (alloc_v),
        .mem_add_o      (mem_add_v),
        .mem_iss_o      (mem_iss_v),
        .mem_done_o     (mem_done_v),
        .pred_add_o     (pred_add_v),
        .pred_iss_o     (pred_iss_v),
        .pred_rel_o     (pred_rel_v),
        .pred_done_o    (pred_done_v),
        .crit_upd_o     (crit_upd_v),
        .crit_val_o     (crit_val),
        .edge_set_o     (edge_set_v),
        .edge_dst_o     (edge_dst_v)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slot
        mdg_group_slot #(.NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (alloc_v[g]),
            .mem_add_i  (mem_add_v[g]),
            .mem_iss_i  (mem_iss_v[g]),
            .mem_cyc_i  (cmd_cyc_i),
            .mem_done_i (mem_done_v[g]),
            .pred_add_i (pred_add_v[g]),
            .pred_iss_i (pred_iss_v[g]),
            .pred_rel_i (pred_rel_v[g]),
            .pred_done_i(pred_done_v[g]),
            .crit_upd_i (crit_upd_v[g]),
            .crit_val_i (crit_val),
            .tick_i     (tick_i),
            .edge_set_i (edge_set_v[g]),
            .edge_data_i(cmd_data_i),
            .edge_dst_i (edge_dst_v),
            .live_o     (live_v[g]),
            .pred_o     (pred_a[g]),
            .mem_o      (mem_a[g]),
            .iss_o      (iss_a[g]),
            .cmp_o      (cmp_a[g]),
            .ord_vec_o  (ord_a[g]),
            .dat_vec_o  (dat_a[g]),
            .crit_mem_o (critm_a[g]),
            .crit_pred_o(crit_o[g*CYC_W +: CYC_W]),
            .waiting_o  (waiting_o[g]),
            .pending_o  (pending_o[g]),
            .ready_o    (ready_o[g]),
            .executing_o(exec_v[g]),
            .executed_o (done_v[g])
        );
    end

    // Purpose: allocate group IDs and latch any rejected command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_id_q <= (ID_W+1)'(1);
            err_q     <= 1'b0;
        end else begin
            if (do_create) next_id_q <= next_id_q + 1'b1;
            if (reject)    err_q     <= 1'b1;
        end
    end

    // Purpose: drive the remaining outputs.
    always_comb begin
        live_o      = live_v;
        executing_o = exec_v;
        executed_o  = done_v;
        next_id_o   = next_id_q;
        err_o       = err_q;
    end

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    p_reject_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> ($stable(live_v) && $stable(next_id_q)));

    p_id_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (next_id_q == $past(next_id_q) || next_id_q == $past(next_id_q) + 1'b1));

    p_live_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((live_v & $past(live_v)) == $past(live_v)));

    p_release_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_rel_v & pred_done_v) == '0);
endmodule

// File: tb/test_mdg_tracker.sv
`timescale 1ns/1ps
module test_mdg_tracker;
    localparam int N  = 16;
    localparam int CW = 4;
    localparam int YW = 6;
    localparam int IW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      cmd_op = '0;
    logic [IW-1:0]   cmd_gid = '0;
    logic [IW-1:0]   cmd_dst = '0;
    logic            cmd_data = 1'b0;
    logic [YW-1:0]   cmd_cyc = '0;
    logic            tick = 1'b0;
    logic [N-1:0]    live_o, waiting_o, pending_o, ready_o, executing_o, executed_o;
    logic [N*YW-1:0] crit_o;
    logic [IW:0]     next_id_o;
    logic            err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mdg_tracker #(.NUM_GROUPS(N), .CNT_W(CW), .CYC_W(YW)) i_mdg_tracker (
        .clk(clk), .rst_n(rst_n), .cmd_op_i(cmd_op), .cmd_gid_i(cmd_gid),
        .cmd_dst_i(cmd_dst), .cmd_data_i(cmd_data), .cmd_cyc_i(cmd_cyc),
        .tick_i(tick), .live_o(live_o), .waiting_o(waiting_o),
        .pending_o(pending_o), .ready_o(ready_o), .executing_o(executing_o),
        .executed_o(executed_o), .crit_o(crit_o), .next_id_o(next_id_o),
        .err_o(err_o)
    );

    // Reference model state, built from the requirements.
    bit         m_live [N];
    int         m_pred [N], m_ipred [N], m_cpred [N];
    int         m_mem [N], m_iss [N], m_cmp [N];
    bit [N-1:0] m_ord [N], m_dat [N];
    int         m_critm [N], m_critp [N];
    int         m_next;
    bit         m_err;

    function automatic bit f_wait(int g);  return m_pred[g] > m_ipred[g] + m_cpred[g]; endfunction
    function automatic bit f_pend(int g);  return m_ipred[g] != 0 && m_ipred[g] + m_cpred[g] == m_pred[g]; endfunction
    function automatic bit f_ready(int g); return m_cpred[g] == m_pred[g]; endfunction
    function automatic bit f_exec(int g);  return m_iss[g] != 0 && m_iss[g] == m_mem[g] - m_cmp[g]; endfunction
    function automatic bit f_done(int g);  return m_cmp[g] == m_mem[g]; endfunction
    function automatic int f_max(int a, int b); return (a > b) ? a : b; endfunction

    task automatic model_reset();
        for (int g = 0; g < N; g++) begin
            m_live[g] = 0; m_pred[g] = 0; m_ipred[g] = 0; m_cpred[g] = 0;
            m_mem[g] = 0; m_iss[g] = 0; m_cmp[g] = 0; m_ord[g] = '0; m_dat[g] = '0;
            m_critm[g] = 0; m_critp[g] = 0;
        end
        m_next = 1;
        m_err  = 0;
    endtask

    task automatic model_step(int op, int g, int d, bit dat, int cyc, bit tk);
        bit rej = 0;
        bit gok = (g != 0) && m_live[g];
        bit dok = (d != 0) && m_live[d];
        for (int s = 0; s < N; s++)
            if (tk && f_wait(s) && m_critp[s] > 0) m_critp[s]--;
        case (op)
            1: if (m_next == N) rej = 1; else begin m_live[m_next] = 1; m_next++; end
            2: if (!gok || m_ord[g] != 0 || m_dat[g] != 0 || m_mem[g] == 15) rej = 1;
               else m_mem[g]++;
            3: begin
                if (!gok || !dok || d == g || f_done(g) || m_ord[g][d] || m_dat[g][d] || m_pred[d] == 15)
                    rej = 1;
                else if (!(!dat && f_exec(g))) begin
                    m_pred[d]++;
                    if (f_exec(g)) begin
                        m_ipred[d]++;
                        if (dat) m_critp[d] = f_max(m_critp[d], m_critm[g]);
                    end
                    if (dat) m_dat[g][d] = 1'b1; else m_ord[g][d] = 1'b1;
                end
            end
            4: if (!gok || m_iss[g] + m_cmp[g] == m_mem[g]) rej = 1;
               else begin
                   m_iss[g]++;
                   m_critm[g] = f_max(m_critm[g], cyc);
                   if (f_exec(g))
                       for (int s = 0; s < N; s++) begin
                           if (m_ord[g][s]) m_cpred[s]++;
                           if (m_dat[g][s]) begin
                               m_ipred[s]++;
                               m_critp[s] = f_max(m_critp[s], m_critm[g]);
                           end
                       end
               end
            5: if (!gok || m_iss[g] == 0) rej = 1;
               else begin
                   m_iss[g]--;
                   m_cmp[g]++;
                   if (m_cmp[g] == m_mem[g])
                       for (int s = 0; s < N; s++)
                           if (m_dat[g][s]) begin m_ipred[s]--; m_cpred[s]++; end
               end
            default: ;
        endcase
        if (rej) m_err = 1;
    endtask

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [N-1:0] el, ew, ep, er, ee, ed;
        for (int g = 0; g < N; g++) begin
            el[g] = m_live[g];
            ew[g] = m_live[g] && f_wait(g);
            ep[g] = m_live[g] && f_pend(g);
            er[g] = m_live[g] && f_ready(g);
            ee[g] = m_live[g] && f_exec(g);
            ed[g] = m_live[g] && f_done(g);
        end
        chk("R1", "live", live_o, el);
        chk("R1", "next_id", next_id_o, m_next);
        chk("R9", "err", err_o, m_err);
        chk("R2", "waiting", waiting_o, ew);
        chk("R2", "pending", pending_o, ep);
        chk("R2", "ready", ready_o, er);
        chk("R3", "executing", executing_o, ee);
        chk("R3", "executed", executed_o, ed);
        for (int g = 0; g < N; g++)
            chk("R8", $sformatf("crit[%0d]", g), crit_o[g*YW +: YW], m_critp[g]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_op = '0; tick = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        compare_all();
    endtask

    task automatic do_cmd(int op, int g, int d, bit dat, int cyc, bit tk);
        cmd_op = 3'(op); cmd_gid = IW'(g); cmd_dst = IW'(d);
        cmd_data = dat; cmd_cyc = YW'(cyc); tick = tk;
        model_step(op, g, d, dat, cyc, tk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        chk("R1", "reset next_id", next_id_o, 1);
        chk("R1", "reset live", live_o, 0);

        // Directed A: order and data release from one source.
        do_cmd(1, 0, 0, 0, 0, 0); do_cmd(1, 0, 0, 0, 0, 0); do_cmd(1, 0, 0, 0, 0, 0);
        chk("R1", "three creates", next_id_o, 4);
        do_cmd(2, 1, 0, 0, 0, 0); do_cmd(2, 1, 0, 0, 0, 0);
        do_cmd(2, 2, 0, 0, 0, 0); do_cmd(2, 3, 0, 0, 0, 0);
        do_cmd(3, 1, 2, 0, 0, 0); do_cmd(3, 1, 3, 1, 0, 0);
        chk("R6", "order target waits", waiting_o[2], 1);
        chk("R6", "data target waits", waiting_o[3], 1);
        do_cmd(4, 1, 0, 0, 5, 0);
        chk("R4", "no release before full issue", waiting_o[2], 1);
        do_cmd(4, 1, 0, 0, 9, 0);
        chk("R4", "order target ready on full issue", ready_o[2], 1);
        chk("R4", "data target pending on full issue", pending_o[3], 1);
        chk("R4", "data target latency", crit_o[3*YW +: YW], 9);
        do_cmd(0, 0, 0, 0, 0, 1);
        chk("R8", "pending group does not age", crit_o[3*YW +: YW], 9);
        do_cmd(5, 1, 0, 0, 0, 0);
        chk("R5", "still pending after one completion", pending_o[3], 1);
        do_cmd(5, 1, 0, 0, 0, 0);
        chk("R5", "data target ready on full completion", ready_o[3], 1);
        do_cmd(2, 1, 0, 0, 0, 0);
        chk("R7", "add member after successor rejected", err_o, 1);
        chk("R7", "member count unchanged", executed_o[1], 1);

        // Directed B: edges added to an executing source, aging, illegal commands.
        do_reset();
        do_cmd(1, 0, 0, 0, 0, 0); do_cmd(1, 0, 0, 0, 0, 0); do_cmd(1, 0, 0, 0, 0, 0);
        do_cmd(2, 1, 0, 0, 0, 0);
        do_cmd(4, 1, 0, 0, 7, 0);
        chk("R3", "single member issued gives executing", executing_o[1], 1);
        do_cmd(3, 1, 2, 0, 0, 0);
        chk("R6", "order edge to executing source is no-op", ready_o[2], 1);
        chk("R6", "order edge no-op raises no error", err_o, 0);
        do_cmd(3, 1, 2, 1, 0, 0);
        chk("R6", "data edge to executing source gives pending", pending_o[2], 1);
        chk("R6", "data edge latency copied", crit_o[2*YW +: YW], 7);
        do_cmd(2, 3, 0, 0, 0, 0);
        do_cmd(3, 3, 2, 1, 0, 0);
        chk("R6", "second predecessor makes target wait", waiting_o[2], 1);
        do_cmd(0, 0, 0, 0, 0, 1);
        chk("R8", "waiting group ages by one", crit_o[2*YW +: YW], 6);
        do_cmd(7, 1, 2, 1, 3, 0);
        chk("R10", "unused code raises no error", err_o, 0);
        do_cmd(6, 3, 0, 0, 3, 0);
        chk("R10", "unused code changes nothing", executing_o, 16'h0002);
        do_cmd(4, 0, 0, 0, 3, 0);
        chk("R9", "group 0 rejected", err_o, 1);
        for (int k = 0; k < 12; k++) do_cmd(1, 0, 0, 0, 0, 0);
        chk("R1", "table full", next_id_o, 16);
        do_cmd(1, 0, 0, 0, 0, 0);
        chk("R1", "create on full table ignored", next_id_o, 16);

        // Random episodes.
        for (int ep = 0; ep < 40; ep++) begin
            do_reset();
            for (int c = 0; c < 250; c++) begin
                int r   = int'($urandom % 100);
                int hi  = (m_next > 1) ? m_next - 1 : 1;
                int op, g, d;
                if      (r < 8)  op = 1;
                else if (r < 28) op = 2;
                else if (r < 50) op = 3;
                else if (r < 72) op = 4;
                else if (r < 92) op = 5;
                else if (r < 97) op = 0;
                else             op = 6 + int'($urandom % 2);
                g = ($urandom % 20 == 0) ? int'($urandom % N) : 1 + int'($urandom % hi);
                d = ($urandom % 20 == 0) ? int'($urandom % N) : 1 + int'($urandom % hi);
                do_cmd(op, g, d, 1'($urandom % 2), int'($urandom % 64), 1'($urandom % 2));
            end
        end

        cmd_op = '0;
        finished = 1;
        finish_run();
    end
endmodule